// File: doc/BRIEF.md
# Cascaded Bit-Slice ALU Datapath

This block is a 16-bit microprogrammed datapath built from four cascaded 4-bit ALU slices. The carry ripples from slice to slice. It holds sixteen general registers and a Q register, and it takes a 16-bit external data word D. Each cycle a microword supplies the following fields:

- a 3-bit operand-pair select;
- a 3-bit function select;
- a 3-bit destination select;
- two 4-bit register addresses A and B;
- a carry-in.

The block returns a 16-bit result Y together with sign, overflow and shift-out flags.

The destination field selects where the ALU result F goes. It can go into Q, into register B, nowhere, or through a right or left shift into register B. The shift can be chained with Q so that register B and Q act as one 32-bit shifter. On a right shift, two microword bits decide the new top bit of the register path. The bit is forced to one, forced to zero, or set to sign XOR overflow, which restores the true sign after an arithmetic overflow. The sequencer and the memory interfaces sit outside this block.

Top module: `bslice_datapath`

## Requirements
- R1: The operand pair (R,S) is chosen by `src_sel_i`: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). Here A and B are the registers addressed by `addr_a_i` and `addr_b_i`.
- R2: `fn_sel_i` chooses F: 0=R+S+cin, 1=S+~R+cin, 2=R+~S+cin, 3=R|S, 4=R&S, 5=~R&S, 6=R^S, 7=~(R^S).
- R3: `sign_o` is F[15`]`. For codes 0 to 2, `ovf_o` is the XOR of the carry into bit 15 and the carry out of bit 15. For codes 3 to 7, `ovf_o` is 0.
- R4: The destination codes write as follows, at the clock edge:
  - 0 writes F to Q.
  - 2 and 3 write F to register B.
  - 1 writes nothing.

  `y_o` shows register A for code 2 and F for every other code.
- R5: Destination 4 writes {fill,F[15:1]} to register B and {F[0],Q[15:1]} to Q. Destination 5 writes {fill,F[15:1]} to register B and leaves Q unchanged.
- R6: The right-shift fill bit is set as follows:
  - it is 1 when `fill_one_i`=1;
  - otherwise it is sign XOR overflow when `fill_sv_i`=1;
  - otherwise it is 0.
- R7: Destination 6 writes {F[14:0],Q[15]} to register B and {Q[14:0],0} to Q. Destination 7 writes {F[14:0],0} to register B and leaves Q unchanged.
- R8: `shift_out_o` takes the bit that leaves the shifter:
  - Q[0] for destination 4;
  - F[0] for destination 5;
  - F[15] for destinations 6 and 7;
  - 0 otherwise.
- R9: After an active-low reset, all registers and Q read as 0.
- R10: Destination 1 leaves every register and Q unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 3 | Operand pair select |
| fn_sel_i | input | 3 | ALU function select |
| dst_sel_i | input | 3 | Destination and shift select |
| addr_a_i | input | 4 | Register A address |
| addr_b_i | input | 4 | Register B address (read and write) |
| cin_i | input | 1 | Carry into the low slice |
| fill_one_i | input | 1 | Force right-shift fill to 1 |
| fill_sv_i | input | 1 | Right-shift fill from sign XOR overflow |
| d_i | input | 16 | External data operand |
| y_o | output | 16 | Result or register A |
| sign_o | output | 1 | F bit 15 |
| ovf_o | output | 1 | Signed overflow |
| shift_out_o | output | 1 | Bit leaving the shifter |

## Verification
A wrong register or Q value cannot be seen directly. It appears on `y_o` or the flags in the first later cycle that uses the corrupted location as an operand or passes register A through. The bench therefore compares every output in every cycle against its own arithmetic model, so a corrupted location shows up within a few operations. A wrong fill bit or a broken Q chain shows up when the shifted register is next read back, one cycle after the write. A carry-chain fault between slices changes F, and with it Y and the flags, in the same cycle.

// File: rtl/bslice_pkg.sv
`timescale 1ns/1ps
package bslice_pkg;
  typedef enum logic [2:0] {
    SRC_AQ, SRC_AB, SRC_ZQ, SRC_ZB, SRC_ZA, SRC_DA, SRC_DQ, SRC_DZ
  } src_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_S_MINUS_R, FN_R_MINUS_S, FN_OR, FN_AND, FN_ANDN_R, FN_XOR, FN_XNOR
  } fn_e;

  typedef enum logic [2:0] {
    DST_LOAD_Q, DST_NONE, DST_REG_SHOW_A, DST_REG,
    DST_SHR_RQ, DST_SHR_R, DST_SHL_RQ, DST_SHL_R
  } dst_e;

  function automatic logic fn_is_arith(fn_e f);
    return (f == FN_ADD) || (f == FN_S_MINUS_R) || (f == FN_R_MINUS_S);
  endfunction
endpackage

// File: rtl/bslice_alu_slice.sv
`timescale 1ns/1ps
module bslice_alu_slice
  import bslice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] s_i,
  input  fn_e          fn_i,
  input  logic         c_i,
  output logic [W-1:0] f_o,
  output logic         c_o
);
  logic [W-1:0] r_eff, s_eff;
  logic [W:0]   sum;

  always_comb begin
    r_eff = (fn_i == FN_S_MINUS_R) ? ~r_i : r_i;
    s_eff = (fn_i == FN_R_MINUS_S) ? ~s_i : s_i;
    sum   = {1'b0, r_eff} + {1'b0, s_eff} + {{W{1'b0}}, c_i};
    c_o   = 1'b0;
    f_o   = '0;
    unique case (fn_i)
      FN_ADD, FN_S_MINUS_R, FN_R_MINUS_S: begin
        f_o = sum[W-1:0];
        c_o = sum[W];
      end
      FN_OR:     f_o = r_i | s_i;
      FN_AND:    f_o = r_i & s_i;
      FN_ANDN_R: f_o = ~r_i & s_i;
      FN_XOR:    f_o = r_i ^ s_i;
      FN_XNOR:   f_o = ~(r_i ^ s_i);
      default:   f_o = '0;
    endcase
  end
endmodule

// File: rtl/bslice_regfile.sv
`timescale 1ns/1ps
module bslice_regfile #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  localparam int NREG = 1 << AW;

  logic [W-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/bslice_dest_unit.sv
`timescale 1ns/1ps
module bslice_dest_unit
  import bslice_pkg::*;
#(
  parameter int W = 16
) (
  input  dst_e         dst_i,
  input  logic [W-1:0] f_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] rd_a_i,
  input  logic         fill_one_i,
  input  logic         fill_sv_i,
  input  logic         sign_i,
  input  logic         ovf_i,
  output logic         rf_we_o,
  output logic [W-1:0] rf_wdata_o,
  output logic         q_we_o,
  output logic [W-1:0] q_next_o,
  output logic [W-1:0] y_o,
  output logic         shift_out_o
);
  logic fill;

  // forced one wins over the sign/overflow correction
  assign fill = fill_one_i | (fill_sv_i & (sign_i ^ ovf_i));

  always_comb begin
    rf_we_o     = 1'b0;
    rf_wdata_o  = f_i;
    q_we_o      = 1'b0;
    q_next_o    = f_i;
    y_o         = f_i;
    shift_out_o = 1'b0;
    unique case (dst_i)
      DST_LOAD_Q: q_we_o = 1'b1;
      DST_NONE:   ;
      DST_REG_SHOW_A: begin
        rf_we_o = 1'b1;
        y_o     = rd_a_i;
      end
      DST_REG: rf_we_o = 1'b1;
      DST_SHR_RQ: begin
        rf_we_o     = 1'b1;
        rf_wdata_o  = {fill, f_i[W-1:1]};
        q_we_o      = 1'b1;
        q_next_o    = {f_i[0], q_i[W-1:1]};
        shift_out_o = q_i[0];
      end
      DST_SHR_R: begin
        rf_we_o     = 1'b1;
        rf_wdata_o  = {fill, f_i[W-1:1]};
        shift_out_o = f_i[0];
      end
      DST_SHL_RQ: begin
        rf_we_o     = 1'b1;
        rf_wdata_o  = {f_i[W-2:0], q_i[W-1]};
        q_we_o      = 1'b1;
        q_next_o    = {q_i[W-2:0], 1'b0};
        shift_out_o = f_i[W-1];
      end
      DST_SHL_R: begin
        rf_we_o     = 1'b1;
        rf_wdata_o  = {f_i[W-2:0], 1'b0};
        shift_out_o = f_i[W-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bslice_datapath.sv
`timescale 1ns/1ps
module bslice_datapath
  import bslice_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 4,
  parameter int AW       = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [2:0]                    src_sel_i,
  input  logic [2:0]                    fn_sel_i,
  input  logic [2:0]                    dst_sel_i,
  input  logic [AW-1:0]                 addr_a_i,
  input  logic [AW-1:0]                 addr_b_i,
  input  logic                          cin_i,
  input  logic                          fill_one_i,
  input  logic                          fill_sv_i,
  input  logic [SLICE_W*N_SLICES-1:0]   d_i,
  output logic [SLICE_W*N_SLICES-1:0]   y_o,
  output logic                          sign_o,
  output logic                          ovf_o,
  output logic                          shift_out_o
);
  localparam int W = SLICE_W * N_SLICES;

  src_e src;
  fn_e  fn;
  dst_e dst;
  assign src = src_e'(src_sel_i);
  assign fn  = fn_e'(fn_sel_i);
  assign dst = dst_e'(dst_sel_i);

  logic [W-1:0] rd_a, rd_b, q_q, op_r, op_s, f_w;
  logic [W-1:0] rf_wdata, q_next;
  logic         rf_we, q_we;
  logic [N_SLICES:0] carry;

  bslice_regfile #(.W(W), .AW(AW)) i_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (addr_b_i),
    .wdata_i   (rf_wdata),
    .raddr_a_i (addr_a_i),
    .raddr_b_i (addr_b_i),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b)
  );

  always_comb begin
    unique case (src)
      SRC_AQ:  begin op_r = rd_a; op_s = q_q;  end
      SRC_AB:  begin op_r = rd_a; op_s = rd_b; end
      SRC_ZQ:  begin op_r = '0;   op_s = q_q;  end
      SRC_ZB:  begin op_r = '0;   op_s = rd_b; end
      SRC_ZA:  begin op_r = '0;   op_s = rd_a; end
      SRC_DA:  begin op_r = d_i;  op_s = rd_a; end
      SRC_DQ:  begin op_r = d_i;  op_s = q_q;  end
      SRC_DZ:  begin op_r = d_i;  op_s = '0;   end
      default: begin op_r = '0;   op_s = '0;   end
    endcase
  end

  assign carry[0] = cin_i;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    bslice_alu_slice #(.W(SLICE_W)) i_slice (
      .r_i  (op_r[i*SLICE_W +: SLICE_W]),
      .s_i  (op_s[i*SLICE_W +: SLICE_W]),
      .fn_i (fn),
      .c_i  (carry[i]),
      .f_o  (f_w[i*SLICE_W +: SLICE_W]),
      .c_o  (carry[i+1])
    );
  end

  // carry into the MSB recovered from the effective adder inputs
  logic r_msb_eff, s_msb_eff, c_into_msb;
  assign r_msb_eff  = (fn == FN_S_MINUS_R) ? ~op_r[W-1] : op_r[W-1];
  assign s_msb_eff  = (fn == FN_R_MINUS_S) ? ~op_s[W-1] : op_s[W-1];
  assign c_into_msb = f_w[W-1] ^ r_msb_eff ^ s_msb_eff;

  assign sign_o = f_w[W-1];
  assign ovf_o  = fn_is_arith(fn) & (c_into_msb ^ carry[N_SLICES]);

  bslice_dest_unit #(.W(W)) i_dest (
    .dst_i       (dst),
    .f_i         (f_w),
    .q_i         (q_q),
    .rd_a_i      (rd_a),
    .fill_one_i  (fill_one_i),
    .fill_sv_i   (fill_sv_i),
    .sign_i      (sign_o),
    .ovf_i       (ovf_o),
    .rf_we_o     (rf_we),
    .rf_wdata_o  (rf_wdata),
    .q_we_o      (q_we),
    .q_next_o    (q_next),
    .y_o         (y_o),
    .shift_out_o (shift_out_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (q_we) q_q <= q_next;
  end
endmodule

// File: rtl/bslice_datapath_chk.sv
`timescale 1ns/1ps
module bslice_datapath_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   dst_i,
  input logic [2:0]   fn_i,
  input logic         fill_one_i,
  input logic [W-1:0] f_i,
  input logic [W-1:0] q_i,
  input logic [W-1:0] rd_a_i,
  input logic [W-1:0] rf_wdata_i,
  input logic [W-1:0] y_i,
  input logic         ovf_i
);
  // R4
  show_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_i == 3'd2) |-> (y_i == rd_a_i));
  // R4
  q_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_i == 3'd0) |=> (q_i == $past(f_i)));
  // R10
  q_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_i == 3'd1) |=> (q_i == $past(q_i)));
  // R5
  q_shr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_i == 3'd4) |=> (q_i == {$past(f_i[0]), $past(q_i[W-1:1])}));
  // R7
  q_shl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_i == 3'd6) |=> (q_i == {$past(q_i[W-2:0]), 1'b0}));
  // R6
  fill_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dst_i == 3'd4 || dst_i == 3'd5) && fill_one_i) |-> rf_wdata_i[W-1]);
  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i >= 3'd3) |-> !ovf_i);
endmodule

bind bslice_datapath bslice_datapath_chk #(.W(W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dst_i      (dst_sel_i),
  .fn_i       (fn_sel_i),
  .fill_one_i (fill_one_i),
  .f_i        (f_w),
  .q_i        (q_q),
  .rd_a_i     (rd_a),
  .rf_wdata_i (rf_wdata),
  .y_i        (y_o),
  .ovf_i      (ovf_o)
);

// File: tb/test_bslice_datapath.sv
`timescale 1ns/1ps
module test_bslice_datapath;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  src_sel_i = '0, fn_sel_i = '0, dst_sel_i = 3'd1;
  logic [3:0]  addr_a_i = '0, addr_b_i = '0;
  logic        cin_i = 1'b0, fill_one_i = 1'b0, fill_sv_i = 1'b0;
  logic [15:0] d_i = '0;
  logic [15:0] y_o;
  logic        sign_o, ovf_o, shift_out_o;

  always #4 clk_i = ~clk_i;

  bslice_datapath i_bslice_datapath (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] regs [16];
  logic [15:0] qm;
  logic [31:0] seed = 32'h1d2c3b4a;

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] s, input logic [2:0] fn, input logic [2:0] ds,
                    input logic c, input logic [3:0] aa, input logic [3:0] bb,
                    input logic [15:0] d, input logic f1, input logic fsv);
    logic [15:0] r, sv, x, yv, f, ye;
    logic [16:0] sum;
    logic [15:0] lo;
    logic ov, fill, so;
    string yt;
    @(negedge clk_i);
    src_sel_i = s; fn_sel_i = fn; dst_sel_i = ds; cin_i = c;
    addr_a_i = aa; addr_b_i = bb; d_i = d; fill_one_i = f1; fill_sv_i = fsv;
    #1;
    case (s) // R1 operand pairs
      3'd0: begin r = regs[aa]; sv = qm; end
      3'd1: begin r = regs[aa]; sv = regs[bb]; end
      3'd2: begin r = 0; sv = qm; end
      3'd3: begin r = 0; sv = regs[bb]; end
      3'd4: begin r = 0; sv = regs[aa]; end
      3'd5: begin r = d; sv = regs[aa]; end
      3'd6: begin r = d; sv = qm; end
      default: begin r = d; sv = 0; end
    endcase
    ov = 1'b0;
    x = r; yv = sv;
    if (fn == 3'd1) x = ~r;
    if (fn == 3'd2) yv = ~sv;
    sum = {1'b0, x} + {1'b0, yv} + {16'd0, c};
    lo  = {1'b0, x[14:0]} + {1'b0, yv[14:0]} + {15'd0, c};
    case (fn) // R2 functions
      3'd0, 3'd1, 3'd2: begin f = sum[15:0]; ov = lo[15] ^ sum[16]; end
      3'd3: f = r | sv;
      3'd4: f = r & sv;
      3'd5: f = ~r & sv;
      3'd6: f = r ^ sv;
      default: f = ~(r ^ sv);
    endcase
    ye = (ds == 3'd2) ? regs[aa] : f;
    fill = f1 | (fsv & (f[15] ^ ov));
    case (ds)
      3'd4: so = qm[0];
      3'd5: so = f[0];
      3'd6, 3'd7: so = f[15];
      default: so = 1'b0;
    endcase
    case (ds)
      3'd4: yt = "R5";
      3'd5: yt = "R6";
      3'd6, 3'd7: yt = "R7";
      3'd1: yt = "R10";
      default: yt = "R4";
    endcase
    chk($sformatf("R1 R2 %s y src%0d fn%0d dst%0d", yt, s, fn, ds), y_o, ye);
    chk("R3 sign", {15'd0, sign_o}, {15'd0, f[15]});
    chk($sformatf("R3 ovf fn%0d", fn), {15'd0, ovf_o}, {15'd0, ov});
    chk($sformatf("R8 shift_out dst%0d", ds), {15'd0, shift_out_o}, {15'd0, so});
    case (ds) // state update, R4 R5 R6 R7
      3'd0: qm = f;
      3'd2, 3'd3: regs[bb] = f;
      3'd4: begin regs[bb] = {fill, f[15:1]}; qm = {f[0], qm[15:1]}; end
      3'd5: regs[bb] = {fill, f[15:1]};
      3'd6: begin regs[bb] = {f[14:0], qm[15]}; qm = {qm[14:0], 1'b0}; end
      3'd7: regs[bb] = {f[14:0], 1'b0};
      default: ;
    endcase
  endtask

  task automatic readback(string tag);
    for (int i = 0; i < 16; i++) begin
      op(3'd4, 3'd0, 3'd1, 1'b0, i[3:0], 4'd0, 16'd0, 1'b0, 1'b0);
      chk($sformatf("%s reg %0d", tag, i), y_o, regs[i]);
    end
    op(3'd2, 3'd0, 3'd1, 1'b0, 4'd0, 4'd0, 16'd0, 1'b0, 1'b0);
    chk($sformatf("%s Q", tag), y_o, qm);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    qm = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    readback("R9 reset");

    // load registers via D+0
    for (int i = 0; i < 16; i++) begin
      seed = nxt(seed);
      op(3'd7, 3'd0, 3'd3, 1'b0, 4'd0, i[3:0], seed[15:0], 1'b0, 1'b0);
    end
    op(3'd7, 3'd0, 3'd0, 1'b0, 4'd0, 4'd0, 16'hA5C3, 1'b0, 1'b0);

    // R3 overflow corner: 0x7FFF + 1
    op(3'd7, 3'd0, 3'd3, 1'b0, 4'd0, 4'd1, 16'h7FFF, 1'b0, 1'b0);
    op(3'd5, 3'd0, 3'd1, 1'b1, 4'd1, 4'd0, 16'h0000, 1'b0, 1'b0);
    chk("R3 ovf 7FFF+1", {15'd0, ovf_o}, 16'd1);
    // R6 fill from sign^ovf: F=8000 with ovf, fill=0 ; register 2
    op(3'd5, 3'd0, 3'd5, 1'b1, 4'd1, 4'd2, 16'h0000, 1'b0, 1'b1);
    op(3'd4, 3'd0, 3'd1, 1'b0, 4'd2, 4'd0, 16'h0, 1'b0, 1'b0);
    chk("R6 fill sign^ovf", y_o, 16'h4000);
    // R6 forced one overrides
    op(3'd7, 3'd0, 3'd5, 1'b0, 4'd0, 4'd3, 16'h0002, 1'b1, 1'b1);
    op(3'd4, 3'd0, 3'd1, 1'b0, 4'd3, 4'd0, 16'h0, 1'b0, 1'b0);
    chk("R6 fill forced", y_o, 16'h8001);
    // R6 plain zero fill of negative value
    op(3'd7, 3'd0, 3'd5, 1'b0, 4'd0, 4'd4, 16'hFFFE, 1'b0, 1'b0);
    op(3'd4, 3'd0, 3'd1, 1'b0, 4'd4, 4'd0, 16'h0, 1'b0, 1'b0);
    chk("R6 fill zero", y_o, 16'h7FFF);
    // R10 no write on dst 1 with B addressed
    op(3'd7, 3'd0, 3'd1, 1'b0, 4'd0, 4'd4, 16'h1234, 1'b0, 1'b0);
    readback("R10 hold");

    // near-exhaustive sweep of control codes
    for (int s = 0; s < 8; s++)
      for (int fn = 0; fn < 8; fn++)
        for (int ds = 0; ds < 8; ds++)
          for (int k = 0; k < 8; k++) begin
            seed = nxt(seed);
            op(s[2:0], fn[2:0], ds[2:0], k[0], seed[19:16], seed[23:20],
               seed[15:0], k[1], k[2]);
          end
    readback("R4 R5 R7 final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule